// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupts

This block is a 32-line general-purpose I/O bank that software controls through a small word-addressed register bus. Each line can be an output (driving a stored value, optionally blinked against a free-running square wave) or an input. Inputs are synchronised, optionally inverted per line, and made readable. They also feed an interrupt path.

The interrupt path has two kinds of cause. A level cause follows the polarity-adjusted input with no storage. An edge cause latches a low-to-high change of the polarity-adjusted input and holds until software clears it. Each kind has its own mask. The masked causes of every eight adjacent lines are ORed into one summary interrupt, which gives four interrupt outputs for the default width. A falling edge or an active-low level is selected by setting the line's polarity bit.

Top module: `gpio_irq_bank`

## Requirements
- R1: Word index selects the register (byte offset = 4 × index): 0 output value, 1 direction, 2 blink enable, 3 input polarity, 4 data-in, 5 edge cause, 6 edge mask, 7 level mask. Writes take effect at the clock edge on which `busWe` is high. `busRdata` shows the selected register combinationally.
- R2: After reset, edge cause, edge mask, level mask, output value, blink enable and polarity read 0. Direction reads all ones, so every line starts as an input.
- R3: A direction bit of 0 makes the line an output: `pinOe` is 1 and `pinOut` carries the output value bit. A direction bit of 1 makes the line an input: `pinOe` is 0 and `pinOut` is 0.
- R4: Data-in bit i reads as `pinIn[i]` after a two-flop synchroniser, XORed with polarity bit i. A change on a pin is visible on the second clock edge after it.
- R5: A 0-to-1 change of the polarity-adjusted input sets its edge cause bit one edge after data-in changes, and the bit stays set. With polarity 1, a falling pin is caught.
- R6: Writing the edge cause register clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R7: If a new edge and a clearing write hit the same cause bit in the same cycle, the bit ends set.
- R8: Line cause = (data-in AND level mask) OR (edge cause AND edge mask). A level cause drops as soon as data-in drops.
- R9: `irqGroup[g]` is the OR of the line causes of lines 8g to 8g+7.
- R10: An output line whose blink bit is set drives its output value ANDed with a square wave whose half-period is 2^BLINK_LOG2 clocks (8 by default).
- R11: A write to data-in (index 4) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busIdx | input | 3 | Register word index |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data of the selected register |
| pinIn | input | 32 | Pad input levels, asynchronous |
| pinOut | output | 32 | Pad output values |
| pinOe | output | 32 | Pad output enables, 1 = drive |
| irqGroup | output | 4 | Summary interrupt per group of eight lines |

## Verification
Two functions can fall in the same cycle: a new edge latched from a pin, and a software write that clears the same edge cause bit. The bench times a pin rise so that the write enable is high exactly on the clock edge where the synchronised rise is detected. It then reads the cause register and expects the bit to be set. A second run uses the same write with no edge present and expects the bit to be cleared, which shows that the write itself did take effect.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    IDX_OUT   = 3'd0,
    IDX_DIR   = 3'd1,
    IDX_BLINK = 3'd2,
    IDX_POL   = 3'd3,
    IDX_DIN   = 3'd4,
    IDX_CAUSE = 3'd5,
    IDX_EMASK = 3'd6,
    IDX_LMASK = 3'd7
  } regIdx_t;

  typedef struct packed {
    logic    wrOut;
    logic    wrDir;
    logic    wrBlink;
    logic    wrPol;
    logic    wrCause;
    logic    wrEdgeMask;
    logic    wrLevelMask;
    regIdx_t rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_IDX_W-1:0] busIdx,
  input  logic                 busWe,
  output ctrlStrobe_t          strobe
);
  always_comb begin
    strobe       = '0;
    strobe.rdSel = regIdx_t'(busIdx);
    if (busWe) begin
      case (regIdx_t'(busIdx))
        IDX_OUT:   strobe.wrOut       = 1'b1;
        IDX_DIR:   strobe.wrDir       = 1'b1;
        IDX_BLINK: strobe.wrBlink     = 1'b1;
        IDX_POL:   strobe.wrPol       = 1'b1;
        IDX_CAUSE: strobe.wrCause     = 1'b1;
        IDX_EMASK: strobe.wrEdgeMask  = 1'b1;
        IDX_LMASK: strobe.wrLevelMask = 1'b1;
        default:   ;
      endcase
    end
  end

  // R1
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrOut, strobe.wrDir, strobe.wrBlink, strobe.wrPol,
              strobe.wrCause, strobe.wrEdgeMask, strobe.wrLevelMask}));

  // R11
  din_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busIdx == IDX_DIN) |-> !(strobe.wrOut | strobe.wrDir | strobe.wrBlink | strobe.wrPol |
                              strobe.wrCause | strobe.wrEdgeMask | strobe.wrLevelMask));
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int LINES      = 32,
  parameter int GROUP      = 8,
  parameter int BLINK_LOG2 = 3,
  localparam int GROUPS    = LINES / GROUP
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [LINES-1:0]  wdata,
  input  logic [LINES-1:0]  pinIn,
  output logic [LINES-1:0]  rdata,
  output logic [LINES-1:0]  pinOut,
  output logic [LINES-1:0]  pinOe,
  output logic [GROUPS-1:0] irqGroup
);
  logic [LINES-1:0] outVal, dirCfg, blinkEn, inPol, edgeMask, levelMask, edgeCause;
  logic [LINES-1:0] syncA, syncB, prevAdj, dataIn, rise, lineCause, drive;
  logic [BLINK_LOG2:0] blinkCnt;
  logic blinkPhase;

  assign dataIn     = syncB ^ inPol;
  assign rise       = dataIn & ~prevAdj;
  assign blinkPhase = blinkCnt[BLINK_LOG2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outVal    <= '0;
      dirCfg    <= '1;
      blinkEn   <= '0;
      inPol     <= '0;
      edgeMask  <= '0;
      levelMask <= '0;
      edgeCause <= '0;
      syncA     <= '0;
      syncB     <= '0;
      prevAdj   <= '0;
      blinkCnt  <= '0;
    end else begin
      syncA    <= pinIn;
      syncB    <= syncA;
      prevAdj  <= dataIn;
      blinkCnt <= blinkCnt + 1'b1;
      if (strobe.wrOut)       outVal    <= wdata;
      if (strobe.wrDir)       dirCfg    <= wdata;
      if (strobe.wrBlink)     blinkEn   <= wdata;
      if (strobe.wrPol)       inPol     <= wdata;
      if (strobe.wrEdgeMask)  edgeMask  <= wdata;
      if (strobe.wrLevelMask) levelMask <= wdata;
      // new edges are ORed after the clear so that an edge wins
      edgeCause <= (strobe.wrCause ? (edgeCause & wdata) : edgeCause) | rise;
    end
  end

  assign drive  = outVal & ~(blinkEn & {LINES{~blinkPhase}});
  assign pinOe  = ~dirCfg;
  assign pinOut = drive & ~dirCfg;

  assign lineCause = (dataIn & levelMask) | (edgeCause & edgeMask);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign irqGroup[g] = |lineCause[g*GROUP +: GROUP];
  end

  always_comb begin
    case (strobe.rdSel)
      IDX_OUT:   rdata = outVal;
      IDX_DIR:   rdata = dirCfg;
      IDX_BLINK: rdata = blinkEn;
      IDX_POL:   rdata = inPol;
      IDX_DIN:   rdata = dataIn;
      IDX_CAUSE: rdata = edgeCause;
      IDX_EMASK: rdata = edgeMask;
      default:   rdata = levelMask;
    endcase
  end

  // R6
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrCause |=> ((edgeCause & $past(edgeCause)) == $past(edgeCause)));

  // R7
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|rise) |=> ((edgeCause & $past(rise)) == $past(rise)));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (edgeMask == '0 && levelMask == '0) |-> (irqGroup == '0));

  // R3
  out_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((pinOut ^ outVal) & pinOe & ~blinkEn) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int LINES      = 32,
  parameter int GROUP      = 8,
  parameter int BLINK_LOG2 = 3,
  localparam int GROUPS    = LINES / GROUP
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_IDX_W-1:0] busIdx,
  input  logic                 busWe,
  input  logic [LINES-1:0]     busWdata,
  output logic [LINES-1:0]     busRdata,
  input  logic [LINES-1:0]     pinIn,
  output logic [LINES-1:0]     pinOut,
  output logic [LINES-1:0]     pinOe,
  output logic [GROUPS-1:0]    irqGroup
);
  ctrlStrobe_t strobe;

  gpio_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busIdx(busIdx), .busWe(busWe), .strobe(strobe)
  );

  gpio_irq_dp #(.LINES(LINES), .GROUP(GROUP), .BLINK_LOG2(BLINK_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata), .pinIn(pinIn),
    .rdata(busRdata), .pinOut(pinOut), .pinOe(pinOe), .irqGroup(irqGroup)
  );
endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busIdx = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe;
  logic [3:0]  irqGroup;

  int checks = 0;
  int errors = 0;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rstN(rstN), .busIdx(busIdx), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqGroup(irqGroup)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    busIdx = idx; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    busIdx = idx;
    #1 d = busRdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd5, d); chk("R2 cause", d, 32'h0);
    rd(3'd6, d); chk("R2 edge mask", d, 32'h0);
    rd(3'd7, d); chk("R2 level mask", d, 32'h0);
    rd(3'd1, d); chk("R2 direction", d, 32'hFFFF_FFFF);
    chk("R2 pinOe", pinOe, 32'h0);
    chk("R2 irq", {28'h0, irqGroup}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(3'd0, 32'hA5A5_0003); rd(3'd0, d); chk("R1 out", d, 32'hA5A5_0003);
    wr(3'd3, 32'h0000_0000); rd(3'd3, d); chk("R1 pol", d, 32'h0);
    wr(3'd2, 32'h1234_5678); rd(3'd2, d); chk("R1 blink", d, 32'h1234_5678);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_dir();
    wr(3'd1, ~32'h3);
    @(negedge clk);
    chk("R3 pinOe", pinOe, 32'h3);
    chk("R3 pinOut", pinOut, 32'h3);
    wr(3'd0, 32'h1);
    chk("R3 pinOut after write", pinOut, 32'h1);
    wr(3'd1, 32'hFFFF_FFFF);
    chk("R3 input lines quiet", pinOut, 32'h0);
  endtask

  task automatic t_datain();
    logic [31:0] d;
    @(negedge clk); pinIn = 32'h0000_0100;
    @(negedge clk);
    rd(3'd4, d); chk("R4 data-in after two edges", d, 32'h0000_0100);
    wr(3'd3, 32'h0000_0300);
    rd(3'd4, d); chk("R4 polarity", d, 32'h0000_0200);
    wr(3'd3, 32'h0); @(negedge clk); pinIn = 32'h0; settle(3);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    @(negedge clk); pinIn[4] = 1'b1; settle(3);
    rd(3'd5, d); chk("R5 rise latched", d, 32'h10);
    @(negedge clk); pinIn[4] = 1'b0; settle(3);
    rd(3'd5, d); chk("R5 held after fall", d, 32'h10);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); chk("R6 write one keeps", d, 32'h10);
    wr(3'd5, ~32'h10);
    rd(3'd5, d); chk("R6 write zero clears", d, 32'h0);
    // falling edge on line 5 through polarity
    @(negedge clk); pinIn[5] = 1'b1;
    wr(3'd3, 32'h20); settle(3);
    wr(3'd5, 32'h0);
    rd(3'd5, d); chk("R5 no cause while high", d, 32'h0);
    @(negedge clk); pinIn[5] = 1'b0; settle(3);
    rd(3'd5, d); chk("R5 falling caught with polarity", d, 32'h20);
    @(negedge clk); pinIn[5] = 1'b1;
    wr(3'd3, 32'h0); @(negedge clk); pinIn[5] = 1'b0; settle(3);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk); pinIn[7] = 1'b1;
    @(negedge clk);
    wr(3'd5, ~32'h80);
    rd(3'd5, d); chk("R7 edge beats clear", d, 32'h80);
    wr(3'd5, ~32'h80);
    rd(3'd5, d); chk("R7 clear alone", d, 32'h0);
    @(negedge clk); pinIn[7] = 1'b0; settle(3);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(3'd5, 32'h0);
    @(negedge clk); pinIn[3] = 1'b1; settle(3);
    chk("R8 edge masked off", {28'h0, irqGroup}, 32'h0);
    wr(3'd6, 32'h8);
    chk("R8 edge unmasked", {28'h0, irqGroup}, 32'h1);
    @(negedge clk); pinIn[3] = 1'b0; settle(3);
    chk("R8 edge stays latched", {28'h0, irqGroup}, 32'h1);
    wr(3'd5, 32'h0); wr(3'd6, 32'h0);
    wr(3'd7, 32'h1000);
    @(negedge clk); pinIn[12] = 1'b1; settle(3);
    chk("R8 level high", {28'h0, irqGroup}, 32'h2);
    @(negedge clk); pinIn[12] = 1'b0; settle(2);
    chk("R8 level no latch", {28'h0, irqGroup}, 32'h0);
    wr(3'd7, 32'hFFFF_FFFF);
    @(negedge clk); pinIn[20] = 1'b1; settle(2);
    chk("R9 group 2", {28'h0, irqGroup}, 32'h4);
    @(negedge clk); pinIn[31] = 1'b1; settle(2);
    chk("R9 groups 2 and 3", {28'h0, irqGroup}, 32'hC);
    @(negedge clk); pinIn = 32'h0; settle(3);
    wr(3'd7, 32'h0); wr(3'd5, 32'h0);
    rd(3'd5, d);
    chk("R9 quiet", {28'h0, irqGroup}, 32'h0);
  endtask

  task automatic t_blink();
    int highs = 0, run = 0, maxRun = 0;
    logic prev = 1'b0;
    logic steadyOk = 1'b1;
    wr(3'd1, ~32'h3); wr(3'd0, 32'h3); wr(3'd2, 32'h2);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (pinOut[1]) highs++;
      if (pinOut[0] !== 1'b1) steadyOk = 1'b0;
      if (i > 0 && pinOut[1] == prev) run++; else run = 1;
      if (run > maxRun) maxRun = run;
      prev = pinOut[1];
    end
    chk("R10 high cycles", highs, 32'd16);
    chk("R10 half period", maxRun, 32'd8);
    chk("R10 non-blink line steady", {31'h0, steadyOk}, 32'h1);
    wr(3'd2, 32'h0); wr(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_din_write();
    logic [31:0] d;
    wr(3'd6, 32'h0000_00F0);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd6, d); chk("R11 edge mask untouched", d, 32'h0000_00F0);
    rd(3'd0, d); chk("R11 out untouched", d, 32'h3);
    rd(3'd4, d); chk("R11 data-in untouched", d, 32'h0);
    rd(3'd3, d); chk("R11 polarity untouched", d, 32'h0);
  endtask

  initial begin
    settle(3);
    rstN = 1'b1;
    settle(2);
    t_reset();
    t_regs();
    t_dir();
    t_datain();
    t_edge();
    t_collide();
    t_irq();
    t_blink();
    t_din_write();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule